// File: doc/BRIEF.md
# Segmented DAC Code Splitter

This block prepares a binary converter code for a segmented digital-to-analogue converter. The upper `MSB_W` bits of each code are expanded into a unary (thermometer) word of `2^MSB_W - 1` equal-weight lines. The unary word drives a network of matched elements. The remaining lower bits go untouched to a binary-weighted ladder.

Both segments are registered. The binary bits are delayed by exactly the same number of clocks as the decoded lines, so a new code reaches every converter input on the same clock edge. This prevents glitches caused by one segment switching before the other. A valid flag travels alongside the data with the same delay.

A new code may be presented on every clock. `MSB_W` may be set from 3 to 5 and the code width is a parameter (16 by default).

Top module: `segdac_encoder`

## Requirements
- R1: Two clocks after a code is sampled, the number of asserted unary lines equals the unsigned value m of the code's top `MSB_W` bits (0 to 15 with the defaults).
- R2: Exactly the lowest m unary lines are asserted: line k (bit k of `seg_unary`, counting from bit 0) is high if and only if m > k.
- R3: `seg_binary` equals the low `CODE_W - MSB_W` bits of the code, in the same bit order, two clocks after the code is sampled.
- R4: The unary and binary outputs for one code appear on the same clock. Both have a latency of exactly two clocks, and a new code is accepted every clock.
- R5: `seg_valid` equals the `code_valid` input sampled two clocks earlier.
- R6: While `rst_n` is low at a rising edge, all outputs are cleared on that edge, which matches the output for code zero with valid low. The inputs present during reset do not appear at the outputs.
- R7: `code_valid` has no effect on the data path: codes move through and update the outputs whether or not they are flagged valid.
- R8: Code zero yields all outputs low, and the all-ones code yields all `2^MSB_W - 1` unary lines and every binary bit high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | CODE_W | Binary converter code, MSB first |
| code_valid | input | 1 | Marks `code_in` as a real sample |
| seg_unary | output | 2^MSB_W-1 | Thermometer lines, bit 0 switches first |
| seg_binary | output | CODE_W-MSB_W | Lower code bits for the binary ladder |
| seg_valid | output | 1 | Delayed copy of `code_valid` |

## Verification
The embedded properties compare outputs with inputs two clocks back. They only apply after two clocks out of reset, so that the reference value is a sampled input and not a pre-reset value.

They require the inputs to be settled at each rising edge. The bench meets this by changing inputs only on falling edges.

Every possible code is streamed back to back, so every field value and every binary pattern is checked against arithmetic expectations. The valid flag follows a pattern that is independent of the code value.

The bench also holds reset with full-scale inputs applied, and it asserts reset in the middle of the stream to confirm the clear.

// File: rtl/segdac_pkg.sv
// Package: shared constants and width helpers for the segmented DAC encoder.
// Assumes callers pass an MSB field width inside the supported range.
package segdac_pkg;

    // Supported range of the unary field width.
    localparam int unsigned SEG_MSB_MIN = 3;
    localparam int unsigned SEG_MSB_MAX = 5;

    // Clocks from code input to segment outputs.
    localparam int unsigned SEG_LATENCY = 2;

    // Number of thermometer lines for an n-bit field.
    function automatic int unsigned unary_lines(input int unsigned n);
        return (1 << n) - 1;
    endfunction

endpackage

// File: rtl/segdac_capture.sv
// Module: first pipeline stage. Registers the full input code and its
// valid flag on every clock, whether or not the code is flagged valid.
// Assumes: synchronous active-low reset; inputs are stable at the rising edge.
module segdac_capture #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_code,
    input  logic             d_valid,
    output logic [WIDTH-1:0] q_code,
    output logic             q_valid
);

    // Purpose: capture the code and flag, or clear them while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_code  <= '0;
            q_valid <= 1'b0;
        end else begin
            q_code  <= d_code;
            q_valid <= d_valid;
        end
    end

endmodule

// File: rtl/segdac_therm_dec.sv
// Module: combinational binary-to-thermometer decoder. Line k is high
// when the field value exceeds k, so value m lights lines 0..m-1.
// Assumes: LINES == 2**FIELD_W - 1 and FIELD_W is small (3..5).
module segdac_therm_dec #(
    parameter int unsigned FIELD_W = 4,
    parameter int unsigned LINES   = 15
) (
    input  logic [FIELD_W-1:0] field,
    output logic [LINES-1:0]   lines
);

    // One magnitude comparator per line; generated for each line index.
    for (genvar k = 0; k < LINES; k++) begin : g_line
        // Purpose: assert line k when the field is above k.
        always_comb lines[k] = (field > FIELD_W'(k));
    end

endmodule

// File: rtl/segdac_align_pipe.sv
// Module: register chain of DEPTH stages used to balance path latency.
// Assumes: DEPTH >= 1; synchronous active-low reset clears every stage.
module segdac_align_pipe #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            // Purpose: load the first stage from the input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= din;
            end
        end else begin : g_body
            // Purpose: shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/segdac_encoder.sv
// Module: top of the segmented DAC encoder. Stage 1 captures the code.
// Stage 2 registers the decoded unary lines and, through a pipe of the
// same depth, the binary bits and the valid flag, so every output changes
// on the same edge.
// Assumes: MSB_W in 3..5 and CODE_W > MSB_W; inputs settle before the
// rising edge.
module segdac_encoder
    import segdac_pkg::*;
#(
    parameter int unsigned CODE_W = 16,
    parameter int unsigned MSB_W  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [CODE_W-1:0]                 code_in,
    input  logic                              code_valid,
    output logic [unary_lines(MSB_W)-1:0]     seg_unary,
    output logic [CODE_W-MSB_W-1:0]           seg_binary,
    output logic                              seg_valid
);

    localparam int unsigned THERM_W  = unary_lines(MSB_W);
    localparam int unsigned LSB_W    = CODE_W - MSB_W;
    localparam int unsigned TAIL_DEP = SEG_LATENCY - 1;

    // Elaboration-time range check of the field width.
    initial begin
        a_cfg_msb_range: assert (MSB_W >= SEG_MSB_MIN && MSB_W <= SEG_MSB_MAX && CODE_W > MSB_W)
            else $error("segdac_encoder: unsupported MSB_W %0d", MSB_W);
    end

    logic [CODE_W-1:0]  cap_code;
    logic               cap_valid;
    logic [THERM_W-1:0] dec_lines;
    logic [LSB_W:0]     tail_out;

    segdac_capture #(.WIDTH(CODE_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_code  (code_in),
        .d_valid (code_valid),
        .q_code  (cap_code),
        .q_valid (cap_valid)
    );

    segdac_therm_dec #(.FIELD_W(MSB_W), .LINES(THERM_W)) u_dec (
        .field (cap_code[CODE_W-1 -: MSB_W]),
        .lines (dec_lines)
    );

    segdac_align_pipe #(.WIDTH(THERM_W), .DEPTH(TAIL_DEP)) u_unary_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (dec_lines),
        .dout  (seg_unary)
    );

    segdac_align_pipe #(.WIDTH(LSB_W + 1), .DEPTH(TAIL_DEP)) u_binary_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cap_valid, cap_code[LSB_W-1:0]}),
        .dout  (tail_out)
    );

    assign seg_binary = tail_out[LSB_W-1:0];
    assign seg_valid  = tail_out[LSB_W];

    // ---------------- assertions ----------------
    // Counts clocks since reset release so $past(…,2) only sees sampled inputs.
    logic [1:0] warm_cnt;
    // Purpose: saturating count of clocks out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_cnt <= '0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end
    logic warm;
    assign warm = (warm_cnt == 2'd2);

    logic [THERM_W-1:0] unary_plus1;
    assign unary_plus1 = seg_unary + THERM_W'(1);

    // R1: number of lit lines equals the field value two clocks back.
    a_r1_line_count: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> ($countones(seg_unary) == int'($past(code_in[CODE_W-1 -: MSB_W], 2))));

    // R2: lit lines form a contiguous run starting at bit 0.
    a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unary_plus1));

    // R3, R4: binary bits are the low code bits with the same latency.
    a_r3_binary_pass: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (seg_binary == $past(code_in[LSB_W-1:0], 2)));

    // R5: valid flag delayed by the pipeline latency.
    a_r5_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (seg_valid == $past(code_valid, 2)));

    // R6: outputs are clear on the first clock after reset is released.
    a_r6_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (seg_unary == '0 && seg_binary == '0 && !seg_valid));

endmodule

// File: tb/segdac_encoder_bench.sv
`timescale 1ns/1ps
module segdac_encoder_bench;

    localparam int CODE_W  = 16;
    localparam int MSB_W   = 4;
    localparam int THERM_W = (1 << MSB_W) - 1;
    localparam int LSB_W   = CODE_W - MSB_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [CODE_W-1:0]   code_in = '0;
    logic                code_valid = 1'b0;
    logic [THERM_W-1:0]  seg_unary;
    logic [LSB_W-1:0]    seg_binary;
    logic                seg_valid;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    segdac_encoder #(.CODE_W(CODE_W), .MSB_W(MSB_W)) u_segdac_encoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_in    (code_in),
        .code_valid (code_valid),
        .seg_unary  (seg_unary),
        .seg_binary (seg_binary),
        .seg_valid  (seg_valid)
    );

    // History of the inputs driven at the last two falling edges.
    logic [CODE_W-1:0] h_code [2];
    logic              h_val  [2];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare outputs with the input driven two falling edges ago (R1-style checks per field).
    task automatic check_against(input logic [CODE_W-1:0] c, input logic v);
        logic [31:0] exp_u;
        int m;
        m = int'(c >> LSB_W);
        exp_u = (32'd1 << m) - 32'd1;
        check("R1 count", 32'($countones(seg_unary)), 32'(m));
        check("R2 pattern", 32'(seg_unary), exp_u);
        check("R3 binary", 32'(seg_binary), 32'(c[LSB_W-1:0]));
        check("R5 valid", 32'(seg_valid), 32'(v));
    endtask

    task automatic drive(input logic [CODE_W-1:0] c, input logic v);
        code_in    = c;
        code_valid = v;
        h_code[1]  = h_code[0];
        h_val[1]   = h_val[0];
        h_code[0]  = c;
        h_val[0]   = v;
    endtask

    initial begin
        // R6: hold reset with full-scale inputs; outputs must stay clear.
        code_in = '1; code_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 unary in reset", 32'(seg_unary), 32'd0);
        check("R6 binary in reset", 32'(seg_binary), 32'd0);
        check("R6 valid in reset", 32'(seg_valid), 32'd0);
        rst_n = 1'b1;
        h_code[0] = '0; h_code[1] = '0; h_val[0] = 1'b0; h_val[1] = 1'b0;

        // R4: single code, confirm no output change after one clock, arrival after two.
        drive(16'hA5C3, 1'b1);
        @(negedge clk);
        check("R4 early unary", 32'(seg_unary), 32'd0);
        check("R4 early binary", 32'(seg_binary), 32'd0);
        drive(16'h0000, 1'b0);
        @(negedge clk);
        check("R4 unary on time", 32'(seg_unary), 32'h03FF);
        check("R4 binary on time", 32'(seg_binary), 32'h5C3);

        // Full sweep of every code, one per clock (R1, R2, R3, R4, R5, R7).
        // R7: valid follows a pattern independent of the code field.
        for (int i = 0; i < (1 << CODE_W); i++) begin
            drive(CODE_W'(i), ((i * 7) % 3) == 0);
            @(negedge clk);
            check_against(h_code[1], h_val[1]);
        end

        // R8: corner codes.
        drive('0, 1'b1); @(negedge clk); check_against(h_code[1], h_val[1]);
        drive('1, 1'b1); @(negedge clk); check_against(h_code[1], h_val[1]);
        drive('0, 1'b0); @(negedge clk);
        check("R8 full scale unary", 32'(seg_unary), 32'h7FFF);
        check("R8 full scale binary", 32'(seg_binary), 32'hFFF);
        @(negedge clk);
        check("R8 zero unary", 32'(seg_unary), 32'd0);
        check("R8 zero binary", 32'(seg_binary), 32'd0);

        // R7: a code flagged invalid still reaches the outputs.
        drive(16'h7123, 1'b0); @(negedge clk);
        drive(16'h7123, 1'b0); @(negedge clk);
        check("R7 invalid code unary", 32'(seg_unary), 32'h007F);
        check("R7 invalid code binary", 32'(seg_binary), 32'h123);
        check("R7 invalid flag", 32'(seg_valid), 32'd0);

        // R6: reset in mid-stream clears everything on the next edge.
        code_in = '1; code_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 mid unary", 32'(seg_unary), 32'd0);
        check("R6 mid binary", 32'(seg_binary), 32'd0);
        check("R6 mid valid", 32'(seg_valid), 32'd0);
        rst_n = 1'b1;
        drive('0, 1'b0);
        @(negedge clk);
        check("R6 after release", 32'(seg_unary), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5ns * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule